// File: doc/BRIEF.md
# First-Error Locked Memory Error Logger

This block keeps the address, and for corrected errors also the syndrome, of memory errors in four capture registers. The four registers cover corrected errors, uncorrectable errors on demand reads, uncorrectable errors seen by the scrubber, and retry decisions. Error events reach the block as single-cycle strobes. Each strobe carries a class, an origin flag that marks scrubber traffic, a group select, and the address and syndrome of the failing access.

The block also holds two 16-bit status words. The primary word records only the first error type seen after it was last empty. The secondary word collects every later error. Software clears bits in either word with write-one-to-clear masks. Each capture register is frozen by its own pair of bit positions in either status word. As a result it holds the first error of its kind, not the latest one, until software clears those bits again.

Top module: `err_first_logger`

## Requirements
- R1: An accepted event sets exactly one status bit. The bit index is 0 for a corrected error, 1 for an uncorrectable error on a demand read (origin flag low), 2 for an uncorrectable error from the scrubber (origin flag high), and 5 for a retry. The index is raised by 8 when the group select is high. The bit goes into the primary word only if that word is all zero after this cycle's clears; otherwise it goes into the secondary word.
- R2: A corrected event from either origin writes its address and syndrome into the corrected capture register when bits 0 and 8 are clear in both status words. The capture happens in the same cycle that sets the lock bit.
- R3: While bit 0 or bit 8 is set in either status word, the corrected address and syndrome keep their values when further corrected events arrive.
- R4: The uncorrectable capture register takes the address only of uncorrectable events with the origin flag low. It is frozen while bit 1 or bit 9 is set in either word.
- R5: The scrub capture register takes the address only of uncorrectable events with the origin flag high. It is frozen while bit 2 or bit 10 is set in either word.
- R6: The retry capture register takes the address of retry events. It is frozen while bit 5 or bit 13 is set in either word.
- R7: A one in a clear mask clears the matching status bit at the next clock edge. Once a capture register's lock bits are clear in both words, that register accepts new events again.
- R8: When a clear and an event fall in the same cycle, the clear is applied first. The event then picks its status word from the cleared state, sets its bit, and is captured if its lock bits are now clear.
- R9: Class code 3 is reserved. Such an event changes no status bit and no capture register.
- R10: While reset is asserted, both status words and all capture registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_valid | input | 1 | Error event strobe |
| err_cls | input | 2 | Class: 0 corrected, 1 uncorrectable, 2 retry, 3 reserved |
| err_scrub | input | 1 | High when the access came from the scrubber |
| err_alt | input | 1 | Group select; moves the status bit up by 8 |
| err_addr | input | ADDR_W | Address of the failing access |
| err_synd | input | SYND_W | ECC syndrome of the failing access |
| clr_first | input | STAT_W | Write-one-to-clear mask for the primary status word |
| clr_next | input | STAT_W | Write-one-to-clear mask for the secondary status word |
| first_st | output | STAT_W | Primary (first-error) status word |
| next_st | output | STAT_W | Secondary (later-error) status word |
| cor_addr | output | ADDR_W | Captured corrected-error address |
| cor_synd | output | SYND_W | Captured corrected-error syndrome |
| unc_addr | output | ADDR_W | Captured demand uncorrectable address |
| scrub_addr | output | ADDR_W | Captured scrubber uncorrectable address |
| retry_addr | output | ADDR_W | Captured retry address |

## Verification
A wrong lock evaluation shows at the capture outputs one clock after the second event of a kind: the register either moves when it should hold or misses the first capture. A fault in the word-selection rule shows one clock after an event, as a bit in the wrong status word or a primary word with more than one bit set. The tests pay most attention to cycles where a clear and an event coincide, because an evaluation order that is off by one cycle is visible only there.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  typedef enum logic [1:0] {
    CLS_COR = 2'd0,
    CLS_UNC = 2'd1,
    CLS_RTY = 2'd2,
    CLS_RSV = 2'd3
  } err_cls_e;

  localparam int LOG_N   = 4;
  localparam int LOG_COR = 0;
  localparam int LOG_UNC = 1;
  localparam int LOG_SCR = 2;
  localparam int LOG_RTY = 3;

  // Low-group status bit that belongs to each capture register.
  function automatic int lock_lo(input int kind);
    case (kind)
      LOG_COR: lock_lo = 0;
      LOG_UNC: lock_lo = 1;
      LOG_SCR: lock_lo = 2;
      default: lock_lo = 5;
    endcase
  endfunction
endpackage

// File: rtl/errlog_decode.sv
module errlog_decode
  import errlog_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic              valid,
  input  logic [1:0]        cls,
  input  logic              scrub,
  input  logic              alt,
  output logic [STAT_W-1:0] set_vec,
  output logic [LOG_N-1:0]  log_sel
);
  localparam int HALF = STAT_W / 2;

  always_comb begin
    log_sel = '0;
    if (valid) begin
      case (err_cls_e'(cls))
        CLS_COR: log_sel[LOG_COR] = 1'b1;
        CLS_UNC: if (scrub) log_sel[LOG_SCR] = 1'b1;
                 else       log_sel[LOG_UNC] = 1'b1;
        CLS_RTY: log_sel[LOG_RTY] = 1'b1;
        default: log_sel = '0;
      endcase
    end
  end

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < LOG_N; k++) begin
      if (log_sel[k]) begin
        set_vec[lock_lo(k) + (alt ? HALF : 0)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/errlog_status.sv
module errlog_status #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_first,
  input  logic [STAT_W-1:0] clr_next,
  output logic [STAT_W-1:0] first_q,
  output logic [STAT_W-1:0] next_q,
  output logic [STAT_W-1:0] lock_vec
);
  logic [STAT_W-1:0] post_first, post_next;
  logic [STAT_W-1:0] first_d, next_d;
  logic              ev, upd_en;

  always_comb begin
    post_first = first_q & ~clr_first;
    post_next  = next_q & ~clr_next;
    ev         = |set_vec;
    if (ev && (post_first == '0)) begin
      first_d = set_vec;
      next_d  = post_next;
    end else begin
      first_d = post_first;
      next_d  = post_next | set_vec;
    end
    lock_vec = post_first | post_next;
    upd_en   = ev | (|clr_first) | (|clr_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
    end else if (upd_en) begin
      first_q <= first_d;
      next_q  <= next_d;
    end
  end
endmodule

// File: rtl/errlog_slot.sv
module errlog_slot #(
  parameter int W       = 32,
  parameter int STAT_W  = 16,
  parameter int LOCK_LO = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [STAT_W-1:0] lock_vec,
  input  logic [W-1:0]      data,
  output logic [W-1:0]      q
);
  localparam int HALF = STAT_W / 2;

  logic locked, cap_en;

  always_comb begin
    locked = lock_vec[LOCK_LO] | lock_vec[LOCK_LO + HALF];
    cap_en = sel & ~locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (cap_en) begin
      q <= data;
    end
  end
endmodule

// File: rtl/err_first_logger.sv
module err_first_logger
  import errlog_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int ADDR_W = 32,
  parameter int SYND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [1:0]        err_cls,
  input  logic              err_scrub,
  input  logic              err_alt,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYND_W-1:0] err_synd,
  input  logic [STAT_W-1:0] clr_first,
  input  logic [STAT_W-1:0] clr_next,
  output logic [STAT_W-1:0] first_st,
  output logic [STAT_W-1:0] next_st,
  output logic [ADDR_W-1:0] cor_addr,
  output logic [SYND_W-1:0] cor_synd,
  output logic [ADDR_W-1:0] unc_addr,
  output logic [ADDR_W-1:0] scrub_addr,
  output logic [ADDR_W-1:0] retry_addr
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [STAT_W-1:0] set_vec, lock_vec;
  logic [LOG_N-1:0]  log_sel;
  logic [ADDR_W-1:0] slot_addr [LOG_N];
  logic [SYND_W-1:0] cor_synd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  errlog_decode #(.STAT_W(STAT_W)) u_decode (
    .valid   (err_valid),
    .cls     (err_cls),
    .scrub   (err_scrub),
    .alt     (err_alt),
    .set_vec (set_vec),
    .log_sel (log_sel)
  );

  errlog_status #(.STAT_W(STAT_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_vec   (set_vec),
    .clr_first (clr_first),
    .clr_next  (clr_next),
    .first_q   (first_st),
    .next_q    (next_st),
    .lock_vec  (lock_vec)
  );

  for (genvar g = 0; g < LOG_N; g++) begin : g_slot
    if (g == LOG_COR) begin : g_wide
      errlog_slot #(.W(ADDR_W + SYND_W), .STAT_W(STAT_W), .LOCK_LO(lock_lo(g))) u_slot (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .sel      (log_sel[g]),
        .lock_vec (lock_vec),
        .data     ({err_addr, err_synd}),
        .q        ({slot_addr[g], cor_synd_q})
      );
    end else begin : g_narrow
      errlog_slot #(.W(ADDR_W), .STAT_W(STAT_W), .LOCK_LO(lock_lo(g))) u_slot (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .sel      (log_sel[g]),
        .lock_vec (lock_vec),
        .data     (err_addr),
        .q        (slot_addr[g])
      );
    end
  end

  assign cor_addr   = slot_addr[LOG_COR];
  assign cor_synd   = cor_synd_q;
  assign unc_addr   = slot_addr[LOG_UNC];
  assign scrub_addr = slot_addr[LOG_SCR];
  assign retry_addr = slot_addr[LOG_RTY];
endmodule

// File: rtl/err_first_logger_chk.sv
module err_first_logger_chk #(
  parameter int STAT_W = 16,
  parameter int ADDR_W = 32,
  parameter int SYND_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              err_valid,
  input logic [1:0]        err_cls,
  input logic              err_scrub,
  input logic [ADDR_W-1:0] err_addr,
  input logic [STAT_W-1:0] clr_first,
  input logic [STAT_W-1:0] clr_next,
  input logic [STAT_W-1:0] first_st,
  input logic [STAT_W-1:0] next_st,
  input logic [ADDR_W-1:0] cor_addr,
  input logic [SYND_W-1:0] cor_synd,
  input logic [ADDR_W-1:0] unc_addr,
  input logic [ADDR_W-1:0] retry_addr
);
  localparam int HALF = STAT_W / 2;

  logic [STAT_W-1:0] any_st;
  logic              no_clr;
  assign any_st = first_st | next_st;
  assign no_clr = (clr_first == '0) && (clr_next == '0);

  p_first_onehot_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(first_st));

  p_cor_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (any_st[0] || any_st[HALF]) && no_clr |=> $stable(cor_addr) && $stable(cor_synd));

  p_unc_capture_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_valid && err_cls == 2'd1 && !err_scrub && no_clr && !any_st[1] && !any_st[1+HALF]
    |=> unc_addr == $past(err_addr));

  p_retry_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (any_st[5] || any_st[5+HALF]) && no_clr |=> $stable(retry_addr));

  p_clear_first_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_valid && err_cls != 2'd3 && (&clr_first) && (&clr_next)
    |=> $countones(first_st) == 1 && next_st == '0);

  p_reserved_ignored_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_valid && err_cls == 2'd3 && no_clr |=> $stable(first_st) && $stable(next_st));
endmodule

bind err_first_logger err_first_logger_chk #(
  .STAT_W(STAT_W), .ADDR_W(ADDR_W), .SYND_W(SYND_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .err_valid  (err_valid),
  .err_cls    (err_cls),
  .err_scrub  (err_scrub),
  .err_addr   (err_addr),
  .clr_first  (clr_first),
  .clr_next   (clr_next),
  .first_st   (first_st),
  .next_st    (next_st),
  .cor_addr   (cor_addr),
  .cor_synd   (cor_synd),
  .unc_addr   (unc_addr),
  .retry_addr (retry_addr)
);

// File: tb/err_first_logger_bench.sv
module err_first_logger_bench;
  localparam int AW = 16;
  localparam int SW = 8;
  localparam int NV = 17;

  typedef struct packed {
    logic        v;
    logic [1:0]  c;
    logic        s;
    logic        a;
    logic [15:0] addr;
    logic [7:0]  syn;
    logic [15:0] cf;
    logic [15:0] cn;
    logic [15:0] ef;
    logic [15:0] en;
    logic [15:0] eca;
    logic [7:0]  ecs;
    logic [15:0] eu;
    logic [15:0] es;
    logic [15:0] er;
  } vec_t;

  // v c s a addr syn clr_first clr_next | first next cor syn unc scr rty
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 1'b0, 16'h1111, 8'hAA, 16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h1111, 8'hAA, 16'h0000, 16'h0000, 16'h0000},
    '{1'b1, 2'd0, 1'b0, 1'b0, 16'h2222, 8'hBB, 16'h0000, 16'h0000, 16'h0001, 16'h0001, 16'h1111, 8'hAA, 16'h0000, 16'h0000, 16'h0000},
    '{1'b1, 2'd1, 1'b0, 1'b1, 16'h3333, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0201, 16'h1111, 8'hAA, 16'h3333, 16'h0000, 16'h0000},
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'h4444, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0203, 16'h1111, 8'hAA, 16'h3333, 16'h0000, 16'h0000},
    '{1'b1, 2'd1, 1'b1, 1'b0, 16'h5555, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0207, 16'h1111, 8'hAA, 16'h3333, 16'h5555, 16'h0000},
    '{1'b1, 2'd2, 1'b0, 1'b1, 16'h6666, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h2207, 16'h1111, 8'hAA, 16'h3333, 16'h5555, 16'h6666},
    '{1'b1, 2'd3, 1'b0, 1'b0, 16'h7777, 8'h77, 16'h0000, 16'h0000, 16'h0001, 16'h2207, 16'h1111, 8'hAA, 16'h3333, 16'h5555, 16'h6666},
    '{1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 8'h00, 16'hFFFF, 16'h0000, 16'h0000, 16'h2207, 16'h1111, 8'hAA, 16'h3333, 16'h5555, 16'h6666},
    '{1'b1, 2'd0, 1'b0, 1'b0, 16'h8888, 8'hCC, 16'h0000, 16'h0000, 16'h0001, 16'h2207, 16'h1111, 8'hAA, 16'h3333, 16'h5555, 16'h6666},
    '{1'b1, 2'd0, 1'b0, 1'b0, 16'h9999, 8'hDD, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 16'h9999, 8'hDD, 16'h3333, 16'h5555, 16'h6666},
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'hAAAA, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0002, 16'h9999, 8'hDD, 16'hAAAA, 16'h5555, 16'h6666},
    '{1'b1, 2'd2, 1'b0, 1'b0, 16'hBBBB, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0022, 16'h9999, 8'hDD, 16'hAAAA, 16'h5555, 16'hBBBB},
    '{1'b1, 2'd0, 1'b1, 1'b0, 16'h1234, 8'h11, 16'h0000, 16'h0000, 16'h0001, 16'h0023, 16'h9999, 8'hDD, 16'hAAAA, 16'h5555, 16'hBBBB},
    '{1'b1, 2'd0, 1'b1, 1'b0, 16'hCCCC, 8'hEE, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 16'hCCCC, 8'hEE, 16'hAAAA, 16'h5555, 16'hBBBB},
    '{1'b1, 2'd1, 1'b1, 1'b1, 16'hDDDD, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0400, 16'hCCCC, 8'hEE, 16'hAAAA, 16'hDDDD, 16'hBBBB},
    '{1'b1, 2'd1, 1'b1, 1'b0, 16'hEEEE, 8'h00, 16'h0000, 16'h0000, 16'h0001, 16'h0404, 16'hCCCC, 8'hEE, 16'hAAAA, 16'hDDDD, 16'hBBBB},
    '{1'b1, 2'd1, 1'b0, 1'b0, 16'hF0F0, 8'h00, 16'h0001, 16'h0000, 16'h0002, 16'h0404, 16'hCCCC, 8'hEE, 16'hF0F0, 16'hDDDD, 16'hBBBB}
  };

  logic          clk, rst_n;
  logic          err_valid, err_scrub, err_alt;
  logic [1:0]    err_cls;
  logic [AW-1:0] err_addr;
  logic [SW-1:0] err_synd;
  logic [15:0]   clr_first, clr_next;
  logic [15:0]   first_st, next_st;
  logic [AW-1:0] cor_addr, unc_addr, scrub_addr, retry_addr;
  logic [SW-1:0] cor_synd;

  int n_chk, n_bad;
  bit done;

  err_first_logger #(.STAT_W(16), .ADDR_W(AW), .SYND_W(SW)) u_err_first_logger (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_cls(err_cls),
    .err_scrub(err_scrub), .err_alt(err_alt), .err_addr(err_addr), .err_synd(err_synd),
    .clr_first(clr_first), .clr_next(clr_next), .first_st(first_st), .next_st(next_st),
    .cor_addr(cor_addr), .cor_synd(cor_synd), .unc_addr(unc_addr),
    .scrub_addr(scrub_addr), .retry_addr(retry_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string what, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    err_valid = 1'b0; err_cls = 2'd0; err_scrub = 1'b0; err_alt = 1'b0;
    err_addr = '0; err_synd = '0; clr_first = '0; clr_next = '0;
  endtask

  task automatic check_zero(input string tag);
    check({tag, " first"}, "R10", first_st, 16'h0);
    check({tag, " next"},  "R10", next_st, 16'h0);
    check({tag, " cor"},   "R10", cor_addr, 16'h0);
    check({tag, " syn"},   "R10", {8'h0, cor_synd}, 16'h0);
    check({tag, " unc"},   "R10", unc_addr, 16'h0);
    check({tag, " scr"},   "R10", scrub_addr, 16'h0);
    check({tag, " rty"},   "R10", retry_addr, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_zero("reset");                 // R10
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector 7 uses reserved class 3 (R9); vectors 10, 14 and 17 mix clear and event (R7, R8).
    for (int i = 0; i < NV; i++) begin
      err_valid = VECS[i].v; err_cls = VECS[i].c; err_scrub = VECS[i].s;
      err_alt = VECS[i].a; err_addr = VECS[i].addr; err_synd = VECS[i].syn;
      clr_first = VECS[i].cf; clr_next = VECS[i].cn;
      @(negedge clk);
      idle();
      check($sformatf("v%0d first", i), "R1 R7 R8", first_st, VECS[i].ef);
      check($sformatf("v%0d next", i),  "R1 R7 R8 R9", next_st, VECS[i].en);
      check($sformatf("v%0d cor", i),   "R2 R3", cor_addr, VECS[i].eca);
      check($sformatf("v%0d syn", i),   "R2 R3", {8'h0, cor_synd}, {8'h0, VECS[i].ecs});
      check($sformatf("v%0d unc", i),   "R4", unc_addr, VECS[i].eu);
      check($sformatf("v%0d scr", i),   "R5", scrub_addr, VECS[i].es);
      check($sformatf("v%0d rty", i),   "R6", retry_addr, VECS[i].er);
    end

    // R9 directed: a reserved event on an empty state leaves everything untouched.
    clr_first = 16'hFFFF; clr_next = 16'hFFFF;
    @(negedge clk);
    idle();
    err_valid = 1'b1; err_cls = 2'd3; err_addr = 16'h5A5A; err_synd = 8'h5A;
    @(negedge clk);
    idle();
    check("reserved first", "R9", first_st, 16'h0);
    check("reserved next",  "R9", next_st, 16'h0);
    check("reserved cor",   "R9", cor_addr, 16'hCCCC);

    // R10 directed: a reset in mid-run returns every output to zero.
    rst_n = 1'b0;
    @(negedge clk);
    check_zero("midrun reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule